// File: doc/BRIEF.md
# DAC Configuration and Power-On Controller

This block owns the eight-bit configuration byte of a four-channel, ten-bit DAC array and the start-up behaviour that follows from it. Coming out of reset, it first copies the stored configuration byte from nonvolatile storage. It then walks the channels one at a time and fills each channel's volatile code register from the source that byte selects. When every channel is loaded it raises a ready flag. From then on, a serial-bus front end may read or write the configuration byte, and a command decoder may write channel codes.

The byte carries four fields:
- a lock bit, which closes the byte to the bus;
- a two-bit power-on source;
- a powered-down output impedance choice;
- the four-bit device type identifier that the front end matches when it addresses the DACs.

The identifier reserved for the configuration register itself can never be written into that field. A mute pin pair overrides every channel's output code with full scale or zero.

Top module: `dac_cfg_top`

## Requirements
- R1: During reset and for the first four clock edges after reset is released, `ready` is low. It rises on the fifth edge (one edge to fetch the byte, then one per channel) and stays high until the next reset.
- R2: Configuration bits [2:1] choose the power-on code of every channel: 00 gives 0x000, 01 gives 0x3FF, 10 gives 0x200. With 11, channel i gets the `recallCode` value presented while `recallIdx` equals i.
- R3: `devTypeId` always shows configuration bits [7:4]. `pdHighZ` shows bit [3] (1 = high impedance when powered down). The reset value of the byte is 0x5F until the stored byte is fetched.
- R4: When bit [0] is 0, a `cfgWrStb` pulse is acknowledged with `cfgAck` high one cycle later, and the byte takes the written value.
- R5: When bit [0] is 1, write and read strobes get no acknowledge, and the byte does not change.
- R6: A write whose bits [7:4] are 1001 keeps the previous identifier. It still updates bits [3:0] and is still acknowledged.
- R7: When unlocked, a `cfgRdStb` pulse is acknowledged one cycle later, and `cfgRdData` then holds the current byte.
- R8: While `muteN` is low, every channel code reads 0x3FF if `muteHiSel` is 1 and 0x000 if it is 0. Releasing mute restores the volatile codes unchanged.
- R9: After `ready`, a high `chWrEn[i]` loads `chWrCode` into channel i at the next edge. Other channels are left unchanged.
- R10: Before `ready`, configuration strobes and channel writes have no effect and produce no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nvCfg | input | 8 | Stored configuration byte from nonvolatile storage |
| recallIdx | output | 2 | Channel whose stored code is requested during start-up |
| recallCode | input | 10 | Stored code for the channel named by `recallIdx` |
| cfgWrStb | input | 1 | Byte write strobe from the bus front end |
| cfgRdStb | input | 1 | Byte read strobe from the bus front end |
| cfgWrData | input | 8 | Byte to write |
| cfgAck | output | 1 | Acknowledge for the previous cycle's strobe |
| cfgRdData | output | 8 | Byte returned by an acknowledged read |
| chWrEn | input | 4 | Per-channel code write enables |
| chWrCode | input | 10 | Code to write into the enabled channels |
| muteN | input | 1 | Mute, active low |
| muteHiSel | input | 1 | Mute level: 1 = full scale, 0 = zero |
| devTypeId | output | 4 | Device type identifier for DAC addressing |
| pdHighZ | output | 1 | Powered-down output mode, 1 = high impedance |
| ready | output | 1 | Start-up sequence complete |
| dacCodes | output | 40 | Channel codes after mute, channel i at bits [10i+9:10i] |

## Verification
The bench brings the block up from each of the four power-on sources. It gives every channel a distinct stored code, so a recall that uses the wrong index, or that samples before the fetched byte is in place, shows a wrong code on some channel.

It holds bus and channel writes active throughout start-up. A design that opened the front end early would acknowledge a strobe or overwrite a freshly recalled code.

It writes the reserved identifier and checks that the old identifier survives while the low nibble changes. It then locks the byte and checks both that a locked design stays silent and that the byte stays unchanged.

Mute is applied at both levels and then released. This catches an override that corrupts the stored codes instead of just masking them.

// File: rtl/dac_cfg_pkg.sv
package dac_cfg_pkg;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'b00,
    SRC_ONES = 2'b01,
    SRC_MID  = 2'b10,
    SRC_NV   = 2'b11
  } srcSel_e;

  typedef struct packed {
    logic    seqLoad;
    srcSel_e seqSrc;
    logic    busEn;
  } dpStrobe_t;

  localparam int          CFG_W          = 8;
  localparam logic [3:0]  CFG_RESERVED_ID = 4'b1001;
  localparam logic [7:0]  CFG_FACTORY    = 8'h5F;

endpackage

// File: rtl/dac_cfg_ctrl.sv
module dac_cfg_ctrl
  import dac_cfg_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int IDXW = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] nvCfg,
  input  logic             cfgWrStb,
  input  logic             cfgRdStb,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic             cfgAck,
  output logic [CFG_W-1:0] cfgRdData,
  output logic [CFG_W-1:0] cfgQ,
  output logic [IDXW-1:0]  seqIdx,
  output logic             ready,
  output dpStrobe_t        stb
);

  typedef enum logic [1:0] {ST_FETCH, ST_FILL, ST_RUN} state_e;

  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NCH - 1);

  state_e     state;
  logic       locked;
  logic [3:0] nextId;

  assign locked = cfgQ[0];
  assign nextId = (cfgWrData[7:4] == CFG_RESERVED_ID) ? cfgQ[7:4] : cfgWrData[7:4];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_FETCH;
      cfgQ      <= CFG_FACTORY;
      seqIdx    <= '0;
      cfgAck    <= 1'b0;
      cfgRdData <= '0;
    end else begin
      cfgAck <= 1'b0;
      case (state)
        ST_FETCH: begin
          cfgQ   <= nvCfg;
          seqIdx <= '0;
          state  <= ST_FILL;
        end
        ST_FILL: begin
          if (seqIdx == LAST_IDX) state <= ST_RUN;
          else                    seqIdx <= seqIdx + 1'b1;
        end
        default: begin
          if (cfgWrStb && !locked) begin
            cfgAck <= 1'b1;
            cfgQ   <= {nextId, cfgWrData[3:0]};
          end else if (cfgRdStb && !locked) begin
            cfgAck    <= 1'b1;
            cfgRdData <= cfgQ;
          end
        end
      endcase
    end
  end

  always_comb begin
    stb.seqLoad = (state == ST_FILL);
    stb.seqSrc  = srcSel_e'(cfgQ[2:1]);
    stb.busEn   = (state == ST_RUN);
  end

  assign ready = (state == ST_RUN);

endmodule

// File: rtl/dac_cfg_dp.sv
module dac_cfg_dp
  import dac_cfg_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CW   = 10,
  parameter int IDXW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [IDXW-1:0]   seqIdx,
  input  logic [CW-1:0]     recallCode,
  input  logic [NCH-1:0]    chWrEn,
  input  logic [CW-1:0]     chWrCode,
  input  logic              muteN,
  input  logic              muteHiSel,
  output logic [NCH*CW-1:0] dacCodes
);

  localparam logic [CW-1:0] CODE_ONES = {CW{1'b1}};
  localparam logic [CW-1:0] CODE_MID  = CW'(1) << (CW - 1);
  localparam logic [CW-1:0] CODE_ZERO = '0;

  logic [CW-1:0] seqCode;
  logic [CW-1:0] muteCode;

  always_comb begin
    case (stb.seqSrc)
      SRC_ZERO: seqCode = CODE_ZERO;
      SRC_ONES: seqCode = CODE_ONES;
      SRC_MID:  seqCode = CODE_MID;
      default:  seqCode = recallCode;
    endcase
  end

  assign muteCode = muteHiSel ? CODE_ONES : CODE_ZERO;

  for (genvar gi = 0; gi < NCH; gi++) begin : gChan
    logic [CW-1:0] volQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        volQ <= CODE_ZERO;
      end else if (stb.seqLoad) begin
        if (seqIdx == IDXW'(gi)) volQ <= seqCode;
      end else if (stb.busEn && chWrEn[gi]) begin
        volQ <= chWrCode;
      end
    end

    assign dacCodes[gi*CW +: CW] = muteN ? volQ : muteCode;
  end

endmodule

// File: rtl/dac_cfg_top.sv
module dac_cfg_top
  import dac_cfg_pkg::*;
#(
  parameter  int NCH  = 4,
  parameter  int CW   = 10,
  localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        nvCfg,
  output logic [IDXW-1:0]   recallIdx,
  input  logic [CW-1:0]     recallCode,
  input  logic              cfgWrStb,
  input  logic              cfgRdStb,
  input  logic [7:0]        cfgWrData,
  output logic              cfgAck,
  output logic [7:0]        cfgRdData,
  input  logic [NCH-1:0]    chWrEn,
  input  logic [CW-1:0]     chWrCode,
  input  logic              muteN,
  input  logic              muteHiSel,
  output logic [3:0]        devTypeId,
  output logic              pdHighZ,
  output logic              ready,
  output logic [NCH*CW-1:0] dacCodes
);

  dpStrobe_t       stb;
  logic [7:0]      cfgQ;
  logic [IDXW-1:0] seqIdx;

  dac_cfg_ctrl #(.NCH(NCH), .IDXW(IDXW)) uCtrl (
    .clk(clk), .rstN(rstN), .nvCfg(nvCfg),
    .cfgWrStb(cfgWrStb), .cfgRdStb(cfgRdStb), .cfgWrData(cfgWrData),
    .cfgAck(cfgAck), .cfgRdData(cfgRdData), .cfgQ(cfgQ),
    .seqIdx(seqIdx), .ready(ready), .stb(stb)
  );

  dac_cfg_dp #(.NCH(NCH), .CW(CW), .IDXW(IDXW)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .seqIdx(seqIdx),
    .recallCode(recallCode), .chWrEn(chWrEn), .chWrCode(chWrCode),
    .muteN(muteN), .muteHiSel(muteHiSel), .dacCodes(dacCodes)
  );

  assign recallIdx = seqIdx;
  assign devTypeId = cfgQ[7:4];
  assign pdHighZ   = cfgQ[3];

endmodule

// File: rtl/dac_cfg_chk.sv
module dac_cfg_chk #(
  parameter int NCH = 4,
  parameter int CW  = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrStb,
  input logic              cfgRdStb,
  input logic              cfgAck,
  input logic [7:0]        cfgQ,
  input logic              ready,
  input logic              muteN,
  input logic              muteHiSel,
  input logic [NCH*CW-1:0] dacCodes
);

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready); // R1

  AST_LOCKED_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (ready && cfgQ[0] && (cfgWrStb || cfgRdStb)) |=> !cfgAck); // R5

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ready && cfgQ[0]) |=> $stable(cfgQ)); // R5

  AST_NO_EARLY_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !ready |=> !cfgAck); // R10

  AST_ACK_HAS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    cfgAck |-> $past(cfgWrStb || cfgRdStb)); // R4

  AST_RESERVED_ID_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (ready && $past(ready) && cfgAck && $past(cfgWrStb)) |-> (cfgQ[7:4] != 4'b1001)); // R6

  for (genvar gi = 0; gi < NCH; gi++) begin : gMute
    AST_MUTE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
      !muteN |-> (dacCodes[gi*CW +: CW] == (muteHiSel ? {CW{1'b1}} : {CW{1'b0}}))); // R8
  end

endmodule

bind dac_cfg_top dac_cfg_chk #(.NCH(NCH), .CW(CW)) uChk (
  .clk(clk), .rstN(rstN), .cfgWrStb(cfgWrStb), .cfgRdStb(cfgRdStb),
  .cfgAck(cfgAck), .cfgQ(cfgQ), .ready(ready), .muteN(muteN),
  .muteHiSel(muteHiSel), .dacCodes(dacCodes)
);

// File: tb/sim_dac_cfg_top.sv
module sim_dac_cfg_top;

  localparam int NCH = 4;
  localparam int CW  = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [7:0]    nvCfg = 8'h00;
  logic [1:0]    recallIdx;
  logic [CW-1:0] recallCode;
  logic          cfgWrStb = 1'b0, cfgRdStb = 1'b0;
  logic [7:0]    cfgWrData = 8'h00;
  logic          cfgAck;
  logic [7:0]    cfgRdData;
  logic [NCH-1:0] chWrEn = '0;
  logic [CW-1:0] chWrCode = '0;
  logic          muteN = 1'b1, muteHiSel = 1'b0;
  logic [3:0]    devTypeId;
  logic          pdHighZ, ready;
  logic [NCH*CW-1:0] dacCodes;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  // stored code per channel: 0x100 + 3*index
  assign recallCode = 10'h100 + 10'(recallIdx) * 10'd3;

  dac_cfg_top u0 (
    .clk(clk), .rstN(rstN), .nvCfg(nvCfg), .recallIdx(recallIdx),
    .recallCode(recallCode), .cfgWrStb(cfgWrStb), .cfgRdStb(cfgRdStb),
    .cfgWrData(cfgWrData), .cfgAck(cfgAck), .cfgRdData(cfgRdData),
    .chWrEn(chWrEn), .chWrCode(chWrCode), .muteN(muteN), .muteHiSel(muteHiSel),
    .devTypeId(devTypeId), .pdHighZ(pdHighZ), .ready(ready), .dacCodes(dacCodes)
  );

  localparam int NVEC = 6;
  localparam logic [7:0] CFG_VEC [NVEC] = '{8'h50, 8'h32, 8'hA4, 8'h7E, 8'h5F, 8'h09};

  function automatic logic [CW-1:0] expCode(logic [7:0] c, int ch);
    case (c[2:1])
      2'b00:   return 10'h000;
      2'b01:   return 10'h3FF;
      2'b10:   return 10'h200;
      default: return 10'h100 + 10'(ch) * 10'd3;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic startUp(logic [7:0] c);
    @(negedge clk);
    rstN = 1'b0;
    nvCfg = c;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic strobe(bit wr, logic [7:0] d, bit expAck, string req);
    @(negedge clk);
    cfgWrStb = wr;
    cfgRdStb = !wr;
    cfgWrData = d;
    @(negedge clk);
    cfgWrStb = 1'b0;
    cfgRdStb = 1'b0;
    chk(req, 32'(cfgAck), 32'(expAck));
  endtask

  task automatic checkCodes(logic [7:0] c, string req);
    for (int ch = 0; ch < NCH; ch++)
      chk(req, 32'(dacCodes[ch*CW +: CW]), 32'(expCode(c, ch)));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R3 / R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 reset ready", 32'(ready), 0);
    chk("R3 reset id", 32'(devTypeId), 5);
    chk("R3 reset pdHighZ", 32'(pdHighZ), 1);

    // R1: ready timing, R10: strobes and writes held during start-up
    nvCfg = 8'h72;
    cfgWrStb = 1'b1; cfgWrData = 8'hC0;
    chWrEn = '1; chWrCode = 10'h155;
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 not ready at edge 4", 32'(ready), 0);
    chk("R10 no ack during start-up", 32'(cfgAck), 0);
    @(negedge clk);
    chk("R1 ready at edge 5", 32'(ready), 1);
    cfgWrStb = 1'b0; chWrEn = '0;
    chk("R10 start-up codes not overwritten", 32'(dacCodes[0 +: CW]), 32'h3FF);
    chk("R10 byte not overwritten", 32'(devTypeId), 7);

    // table of power-on configurations: R2, R3
    for (int v = 0; v < NVEC; v++) begin
      startUp(CFG_VEC[v]);
      chk("R1 ready after start-up", 32'(ready), 1);
      chk("R3 id", 32'(devTypeId), 32'(CFG_VEC[v][7:4]));
      chk("R3 pdHighZ", 32'(pdHighZ), 32'(CFG_VEC[v][3]));
      checkCodes(CFG_VEC[v], "R2 power-on code");
    end

    // unlocked bus access
    startUp(8'h50);
    strobe(1'b1, 8'h3C, 1'b1, "R4 write ack");
    chk("R4 write id", 32'(devTypeId), 3);
    chk("R4 write pdHighZ", 32'(pdHighZ), 1);
    strobe(1'b0, 8'h00, 1'b1, "R7 read ack");
    chk("R7 read data", 32'(cfgRdData), 32'h3C);

    // R6: reserved identifier
    strobe(1'b1, 8'h96, 1'b1, "R6 reserved id write ack");
    chk("R6 id kept", 32'(devTypeId), 3);
    chk("R6 pdHighZ updated", 32'(pdHighZ), 0);
    strobe(1'b0, 8'h00, 1'b1, "R6 read ack");
    chk("R6 low nibble updated", 32'(cfgRdData), 32'h36);

    // R5: lock
    strobe(1'b1, 8'h21, 1'b1, "R5 locking write ack");
    strobe(1'b1, 8'h40, 1'b0, "R5 locked write nack");
    chk("R5 locked id unchanged", 32'(devTypeId), 2);
    strobe(1'b0, 8'h00, 1'b0, "R5 locked read nack");
    chk("R5 read data not refreshed", 32'(cfgRdData), 32'h36);

    // R9: channel write
    @(negedge clk);
    chWrEn = 4'b0100; chWrCode = 10'h2AB;
    @(negedge clk);
    chWrEn = '0;
    chk("R9 ch2 written", 32'(dacCodes[2*CW +: CW]), 32'h2AB);
    chk("R9 ch1 untouched", 32'(dacCodes[1*CW +: CW]), 32'h000);
    chk("R9 ch3 untouched", 32'(dacCodes[3*CW +: CW]), 32'h000);

    // R8: mute
    @(negedge clk);
    muteN = 1'b0; muteHiSel = 1'b1;
    @(negedge clk);
    for (int ch = 0; ch < NCH; ch++)
      chk("R8 mute high", 32'(dacCodes[ch*CW +: CW]), 32'h3FF);
    muteHiSel = 1'b0;
    @(negedge clk);
    for (int ch = 0; ch < NCH; ch++)
      chk("R8 mute low", 32'(dacCodes[ch*CW +: CW]), 32'h000);
    muteN = 1'b1;
    @(negedge clk);
    chk("R8 restored ch2", 32'(dacCodes[2*CW +: CW]), 32'h2AB);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule